// File: doc/BRIEF.md
# Amplifier Channel Operating-State Controller

This block supervises one class-D amplifier channel. It decides whether the channel is powered down, qualifying its supply and output wiring, idling with switching stopped, switching silently, playing, running a load diagnostic, or parked because the supply is too high. It takes level inputs from the enable decoder, the register bank, the clock and supply monitors and the protection circuits, plus single-cycle command pulses from the register interface. It drives a state code, the PWM enable for the modulator and an output-bias flag for the output stage. It also drives a status bit that flags a protection fault that has been present for the whole qualification window.

There are seven states. Standby is code 0 and is the reset state. Supply/short qualification is code 1. Eco is code 2: the channel is live but not switching. Mute is code 3: switching, no audio. Play is code 4. Load diagnostic is code 5. Dump is code 6: overvoltage park. The named transitions are: leave-standby (0 to 1), qualified (1 to 2), switch-on (2 to 3), switch-off (3 to 2), play (3 to 4), mute (4 to 3), diag-start (3 to 5), diag-done (5 to 3), overvoltage-park (any non-standby state to 6), overvoltage-release (6 to 1), protect (2/3/4/5 to 1) and drop-out (any state to 0). The qualification window lasts CLK_KHZ × QUAL_MS clock cycles, so a bench can shorten it.

Top module: `amp_state_ctrl`

## Requirements
- R1: After reset the state code is 0 (Standby), and pwm_en, out_bias and stable_fault are all 0. The state codes are Standby 0, qualification 1, Eco 2, Mute 3, Play 4, load diagnostic 5 and Dump 6. Code 7 never appears.
- R2: Standby moves to qualification (1) on the clock edge where en_valid and regs_programmed are both high and no drop-out cause is present. Otherwise Standby is held.
- R3: Let N = CLK_KHZ × QUAL_MS. Qualification moves to Eco only after N consecutive sampled cycles with no protection fault. The protection faults are flt_short, flt_ovc, flt_uv and flt_thermal. A fault in any single cycle restarts the count from zero, so a clean entry spends exactly N cycles in state 1.
- R4: stable_fault goes high after N consecutive fault cycles in qualification. It stays high while the fault persists and clears on the first fault-free cycle or on leaving state 1.
- R5: A cmd_pwm_on pulse moves Eco to Mute, and a cmd_pwm_off pulse moves Mute back to Eco.
- R6: cmd_play moves Mute to Play. cmd_mute or a high auto_mute moves Play back to Mute. When several commands arrive together in Mute, the priority is switch-off, then play, then diag-start.
- R7: cmd_diag_start moves Mute to load diagnostic (5). The state stays 5 until diag_done is high, then returns to Mute.
- R8: ov_above moves any non-Standby state to Dump (6), which is held while ov_above stays high. When ov_above falls, the state goes to qualification (1), never to the state it came from.
- R9: Any protection fault in Eco, Mute, Play or load diagnostic returns the state to qualification (1).
- R10: Any drop-out cause forces Standby on the next edge from every state and clears out_bias. The drop-out causes are en_off, supply_reset, pll_lock low and i2s_clk_ok low.
- R11: pwm_en is high only in Mute, Play and load diagnostic. out_bias is high in every state except Standby.
- R12: Priority per cycle is drop-out, then overvoltage, then protection fault, then commands. A command with no transition defined in the current state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_valid | input | 1 | Enable pin code is a legal operating code |
| en_off | input | 1 | Enable pin code is all zeros |
| regs_programmed | input | 1 | Control registers written at least once |
| supply_reset | input | 1 | Supply at system-reset level |
| pll_lock | input | 1 | Audio PLL locked |
| i2s_clk_ok | input | 1 | Serial audio bit clock present and correct |
| ov_above | input | 1 | Supply above overvoltage limit |
| flt_short | input | 1 | Output short to supply or ground |
| flt_ovc | input | 1 | Overcurrent |
| flt_uv | input | 1 | Undervoltage lockout |
| flt_thermal | input | 1 | Thermal shutdown |
| auto_mute | input | 1 | Any automatic mute condition |
| cmd_pwm_on | input | 1 | Switch-on command pulse |
| cmd_pwm_off | input | 1 | Switch-off command pulse |
| cmd_play | input | 1 | Play command pulse |
| cmd_mute | input | 1 | Mute command pulse |
| cmd_diag_start | input | 1 | Load diagnostic start pulse |
| diag_done | input | 1 | Load diagnostic routine finished |
| state_code | output | 3 | Current state code |
| pwm_en | output | 1 | Modulator enable |
| out_bias | output | 1 | Output stage biased |
| stable_fault | output | 1 | Protection fault held for a full window |

## Verification
The hardest case to reach from the ports is a single-cycle fault that lands on every possible position inside the qualification window. The last position matters most, because a fault there must cost a full new window and not one extra cycle. The bench shortens the window to eight cycles and sweeps the fault position from the first clean cycle to the last. For each position it counts the cycles until Eco appears. After each pass it uses a protection fault to send the channel from Eco back into qualification, so every trial starts from a fresh entry.

// File: rtl/amp_state_pkg.sv
package amp_state_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY     = 3'd0,
        ST_DIAG_SUPPLY = 3'd1,
        ST_ECO         = 3'd2,
        ST_MUTE        = 3'd3,
        ST_PLAY        = 3'd4,
        ST_DIAG_DC     = 3'd5,
        ST_DUMP        = 3'd6
    } amp_state_e;

    typedef struct packed {
        logic pwm_on;
        logic pwm_off;
        logic play;
        logic mute;
        logic diag_start;
    } amp_cmd_t;

endpackage

// File: rtl/amp_run_timer.sv
// Counts consecutive cycles in which run is high; hit marks the LIMIT-th.
module amp_run_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic hit
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = run && !clr && (cnt_q == LAST);
endmodule

// File: rtl/amp_state_next.sv
// Next-state decision with fixed priority: drop-out, overvoltage, protection, commands.
module amp_state_next
    import amp_state_pkg::*;
(
    input  amp_state_e cur,
    input  logic       force_sb,
    input  logic       exit_ok,
    input  logic       ov,
    input  logic       prot_fault,
    input  logic       qual_done,
    input  amp_cmd_t   cmd,
    input  logic       auto_mute,
    input  logic       diag_done,
    output amp_state_e nxt
);
    always_comb begin
        nxt = cur;
        if (force_sb) begin
            nxt = ST_STANDBY;
        end else if (cur == ST_STANDBY) begin
            if (exit_ok) nxt = ST_DIAG_SUPPLY;
        end else if (ov) begin
            nxt = ST_DUMP;
        end else if (cur == ST_DUMP) begin
            nxt = ST_DIAG_SUPPLY;
        end else if (prot_fault && (cur != ST_DIAG_SUPPLY)) begin
            nxt = ST_DIAG_SUPPLY;
        end else begin
            unique case (cur)
                ST_DIAG_SUPPLY: if (qual_done) nxt = ST_ECO;
                ST_ECO:         if (cmd.pwm_on) nxt = ST_MUTE;
                ST_MUTE: begin
                    if (cmd.pwm_off)         nxt = ST_ECO;
                    else if (cmd.play)       nxt = ST_PLAY;
                    else if (cmd.diag_start) nxt = ST_DIAG_DC;
                end
                ST_PLAY:    if (cmd.mute || auto_mute) nxt = ST_MUTE;
                ST_DIAG_DC: if (diag_done) nxt = ST_MUTE;
                default:    nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/amp_state_out.sv
module amp_state_out
    import amp_state_pkg::*;
(
    input  amp_state_e  cur,
    output logic [2:0]  state_code,
    output logic        pwm_en,
    output logic        out_bias
);
    always_comb begin
        state_code = cur;
        pwm_en     = 1'b0;
        out_bias   = 1'b1;
        unique case (cur)
            ST_STANDBY:     out_bias = 1'b0;
            ST_DIAG_SUPPLY: pwm_en   = 1'b0;
            ST_ECO:         pwm_en   = 1'b0;
            ST_MUTE:        pwm_en   = 1'b1;
            ST_PLAY:        pwm_en   = 1'b1;
            ST_DIAG_DC:     pwm_en   = 1'b1;
            ST_DUMP:        pwm_en   = 1'b0;
            default: begin
                pwm_en   = 1'b0;
                out_bias = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/amp_state_ctrl.sv
module amp_state_ctrl
    import amp_state_pkg::*;
#(
    parameter int CLK_KHZ = 100_000,
    parameter int QUAL_MS = 90
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_valid,
    input  logic       en_off,
    input  logic       regs_programmed,
    input  logic       supply_reset,
    input  logic       pll_lock,
    input  logic       i2s_clk_ok,
    input  logic       ov_above,
    input  logic       flt_short,
    input  logic       flt_ovc,
    input  logic       flt_uv,
    input  logic       flt_thermal,
    input  logic       auto_mute,
    input  logic       cmd_pwm_on,
    input  logic       cmd_pwm_off,
    input  logic       cmd_play,
    input  logic       cmd_mute,
    input  logic       cmd_diag_start,
    input  logic       diag_done,
    output logic [2:0] state_code,
    output logic       pwm_en,
    output logic       out_bias,
    output logic       stable_fault
);
    localparam int QUAL_CYC = CLK_KHZ * QUAL_MS;

    amp_state_e state_q, state_d;
    amp_cmd_t   cmd;
    logic       force_sb, prot_fault, in_diag;
    logic       clean_hit, fault_hit, stable_q;

    assign force_sb   = en_off | supply_reset | ~pll_lock | ~i2s_clk_ok;
    assign prot_fault = flt_short | flt_ovc | flt_uv | flt_thermal;
    assign in_diag    = (state_q == ST_DIAG_SUPPLY);

    assign cmd.pwm_on     = cmd_pwm_on;
    assign cmd.pwm_off    = cmd_pwm_off;
    assign cmd.play       = cmd_play;
    assign cmd.mute       = cmd_mute;
    assign cmd.diag_start = cmd_diag_start;

    // Fault-free run: qualifies the channel out of state 1.
    amp_run_timer #(.LIMIT(QUAL_CYC)) u_clean_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~in_diag),
        .run   (~prot_fault),
        .hit   (clean_hit)
    );

    // Faulted run: drives the stable-fault status bit.
    amp_run_timer #(.LIMIT(QUAL_CYC)) u_fault_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~in_diag),
        .run   (prot_fault),
        .hit   (fault_hit)
    );

    amp_state_next u_next (
        .cur        (state_q),
        .force_sb   (force_sb),
        .exit_ok    (en_valid & regs_programmed),
        .ov         (ov_above),
        .prot_fault (prot_fault),
        .qual_done  (clean_hit),
        .cmd        (cmd),
        .auto_mute  (auto_mute),
        .diag_done  (diag_done),
        .nxt        (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_STANDBY;
            stable_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            stable_q <= fault_hit & ~force_sb & ~ov_above;
        end
    end

    amp_state_out u_out (
        .cur        (state_q),
        .state_code (state_code),
        .pwm_en     (pwm_en),
        .out_bias   (out_bias)
    );

    assign stable_fault = stable_q;
endmodule

// File: rtl/amp_state_ctrl_chk.sv
module amp_state_ctrl_chk #(
    parameter int QUAL_CYC = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en_valid,
    input logic       en_off,
    input logic       regs_programmed,
    input logic       supply_reset,
    input logic       pll_lock,
    input logic       i2s_clk_ok,
    input logic       ov_above,
    input logic       flt_short,
    input logic       flt_ovc,
    input logic       flt_uv,
    input logic       flt_thermal,
    input logic       cmd_pwm_on,
    input logic [2:0] state_code,
    input logic       pwm_en,
    input logic       out_bias,
    input logic       stable_fault
);
    logic drop, fault;
    int   clean_run;

    assign drop  = en_off | supply_reset | ~pll_lock | ~i2s_clk_ok;
    assign fault = flt_short | flt_ovc | flt_uv | flt_thermal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clean_run <= 0;
        else if (state_code == 3'd1 && !fault)
            clean_run <= (clean_run < QUAL_CYC) ? clean_run + 1 : clean_run;
        else clean_run <= 0;
    end

    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        state_code != 3'd7);

    a_r2_leave_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd0 && !drop && en_valid && regs_programmed) |=> state_code == 3'd1);

    a_r2_hold_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd0 && !(en_valid && regs_programmed)) |=> state_code == 3'd0);

    a_r3_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd1 && !drop && !ov_above && (fault || clean_run != QUAL_CYC - 1))
        |=> state_code == 3'd1);

    a_r3_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd1 && !drop && !ov_above && !fault && clean_run == QUAL_CYC - 1)
        |=> state_code == 3'd2);

    a_r4_stable_only_in_diag: assert property (@(posedge clk) disable iff (!rst_n)
        stable_fault |-> state_code == 3'd1);

    a_r5_switch_on: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd2 && cmd_pwm_on && !drop && !ov_above && !fault) |=> state_code == 3'd3);

    a_r8_dump_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 3'd0 && !drop && ov_above) |=> state_code == 3'd6);

    a_r8_dump_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd6 && !drop && !ov_above) |=> state_code == 3'd1);

    a_r9_protect: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code inside {3'd2, 3'd3, 3'd4, 3'd5} && !drop && !ov_above && fault)
        |=> state_code == 3'd1);

    a_r10_drop_out: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (state_code == 3'd0 && !out_bias));

    a_r11_no_switching: assert property (@(posedge clk) disable iff (!rst_n)
        state_code inside {3'd0, 3'd1, 3'd2, 3'd6} |-> !pwm_en);
endmodule

bind amp_state_ctrl amp_state_ctrl_chk #(.QUAL_CYC(QUAL_CYC)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .en_valid        (en_valid),
    .en_off          (en_off),
    .regs_programmed (regs_programmed),
    .supply_reset    (supply_reset),
    .pll_lock        (pll_lock),
    .i2s_clk_ok      (i2s_clk_ok),
    .ov_above        (ov_above),
    .flt_short       (flt_short),
    .flt_ovc         (flt_ovc),
    .flt_uv          (flt_uv),
    .flt_thermal     (flt_thermal),
    .cmd_pwm_on      (cmd_pwm_on),
    .state_code      (state_code),
    .pwm_en          (pwm_en),
    .out_bias        (out_bias),
    .stable_fault    (stable_fault)
);

// File: tb/amp_state_ctrl_tb.sv
module amp_state_ctrl_tb;
    localparam int QN = 8;  // CLK_KHZ=1, QUAL_MS=8
    localparam int S_SB = 0, S_DG = 1, S_ECO = 2, S_MUTE = 3, S_PLAY = 4, S_DC = 5, S_DUMP = 6;

    logic clk = 1'b0;
    logic rst_n;
    logic en_valid, en_off, regs_programmed, supply_reset, pll_lock, i2s_clk_ok;
    logic ov_above, flt_short, flt_ovc, flt_uv, flt_thermal, auto_mute;
    logic cmd_pwm_on, cmd_pwm_off, cmd_play, cmd_mute, cmd_diag_start, diag_done;
    logic [2:0] state_code;
    logic pwm_en, out_bias, stable_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    amp_state_ctrl #(.CLK_KHZ(1), .QUAL_MS(QN)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_valid(en_valid), .en_off(en_off),
        .regs_programmed(regs_programmed), .supply_reset(supply_reset),
        .pll_lock(pll_lock), .i2s_clk_ok(i2s_clk_ok), .ov_above(ov_above),
        .flt_short(flt_short), .flt_ovc(flt_ovc), .flt_uv(flt_uv),
        .flt_thermal(flt_thermal), .auto_mute(auto_mute),
        .cmd_pwm_on(cmd_pwm_on), .cmd_pwm_off(cmd_pwm_off), .cmd_play(cmd_play),
        .cmd_mute(cmd_mute), .cmd_diag_start(cmd_diag_start), .diag_done(diag_done),
        .state_code(state_code), .pwm_en(pwm_en), .out_bias(out_bias),
        .stable_fault(stable_fault)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic st(input string req, input int exp);
        chk(req, "state_code", int'(state_code), exp);
        chk(req, "pwm_en", int'(pwm_en), (exp == S_MUTE || exp == S_PLAY || exp == S_DC) ? 1 : 0);
        chk(req, "out_bias", int'(out_bias), (exp == S_SB) ? 0 : 1);
    endtask

    // From a fresh entry into state 1 with no faults, reach Eco after QN cycles.
    task automatic qualify(input string req);
        for (int j = 1; j <= QN; j++) begin
            tick();
            st(req, (j == QN) ? S_ECO : S_DG);
        end
    endtask

    task automatic eco_to_play();
        cmd_pwm_on = 1; tick(); cmd_pwm_on = 0;
        cmd_play = 1;   tick(); cmd_play = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; en_valid = 0; en_off = 0; regs_programmed = 0; supply_reset = 0;
        pll_lock = 1; i2s_clk_ok = 1; ov_above = 0; flt_short = 0; flt_ovc = 0;
        flt_uv = 0; flt_thermal = 0; auto_mute = 0; cmd_pwm_on = 0; cmd_pwm_off = 0;
        cmd_play = 0; cmd_mute = 0; cmd_diag_start = 0; diag_done = 0;
        repeat (3) @(negedge clk);
        st("R1", S_SB);
        chk("R1", "stable_fault", int'(stable_fault), 0);
        rst_n = 1;
        tick();
        st("R2", S_SB);

        // R2: both conditions needed
        en_valid = 1;
        repeat (3) begin tick(); st("R2", S_SB); end
        regs_programmed = 1;
        tick();
        st("R2", S_DG);

        // R3: single-cycle fault at every position of the window
        for (int k = 0; k < QN; k++) begin
            for (int c = 0; c < k; c++) begin tick(); st("R3", S_DG); end
            flt_short = (k % 4 == 0); flt_ovc = (k % 4 == 1);
            flt_uv = (k % 4 == 2);    flt_thermal = (k % 4 == 3);
            tick();
            st("R3", S_DG);
            flt_short = 0; flt_ovc = 0; flt_uv = 0; flt_thermal = 0;
            qualify("R3");
            flt_uv = 1; tick(); flt_uv = 0;
            st("R9", S_DG);
        end

        // R4: stable fault after QN consecutive fault cycles
        flt_short = 1;
        for (int j = 1; j <= QN; j++) begin
            tick();
            chk("R4", "stable_fault", int'(stable_fault), (j == QN) ? 1 : 0);
            st("R4", S_DG);
        end
        tick();
        chk("R4", "stable_fault held", int'(stable_fault), 1);
        flt_short = 0;
        tick();
        chk("R4", "stable_fault cleared", int'(stable_fault), 0);
        repeat (QN - 1) tick();
        st("R3", S_ECO);

        // R5 / R12
        cmd_pwm_on = 1; tick(); cmd_pwm_on = 0; st("R5", S_MUTE);
        cmd_pwm_off = 1; tick(); cmd_pwm_off = 0; st("R5", S_ECO);
        cmd_play = 1; tick(); cmd_play = 0; st("R12", S_ECO);
        cmd_pwm_on = 1; tick(); cmd_pwm_on = 0; st("R5", S_MUTE);

        // R6
        cmd_play = 1; tick(); cmd_play = 0; st("R6", S_PLAY);
        cmd_pwm_on = 1; tick(); cmd_pwm_on = 0; st("R12", S_PLAY);
        cmd_mute = 1; tick(); cmd_mute = 0; st("R6", S_MUTE);
        cmd_play = 1; tick(); cmd_play = 0; st("R6", S_PLAY);
        auto_mute = 1; tick(); auto_mute = 0; st("R6", S_MUTE);
        cmd_pwm_off = 1; cmd_play = 1; tick(); cmd_pwm_off = 0; cmd_play = 0;
        st("R6", S_ECO);
        cmd_pwm_on = 1; tick(); cmd_pwm_on = 0; st("R5", S_MUTE);
        cmd_play = 1; cmd_diag_start = 1; tick(); cmd_play = 0; cmd_diag_start = 0;
        st("R6", S_PLAY);
        cmd_mute = 1; tick(); cmd_mute = 0; st("R6", S_MUTE);

        // R7
        cmd_diag_start = 1; tick(); cmd_diag_start = 0; st("R7", S_DC);
        repeat (3) begin tick(); st("R7", S_DC); end
        diag_done = 1; tick(); diag_done = 0; st("R7", S_MUTE);

        // R12 / R8: overvoltage beats protection fault and command
        ov_above = 1; flt_ovc = 1; cmd_play = 1;
        tick();
        flt_ovc = 0; cmd_play = 0;
        st("R12", S_DUMP);
        repeat (2) begin tick(); st("R8", S_DUMP); end
        ov_above = 0; tick(); st("R8", S_DG);
        qualify("R3");
        eco_to_play();
        st("R6", S_PLAY);

        // R9: each protection fault from Play
        for (int c = 0; c < 4; c++) begin
            flt_short = (c == 0); flt_ovc = (c == 1); flt_uv = (c == 2); flt_thermal = (c == 3);
            tick();
            flt_short = 0; flt_ovc = 0; flt_uv = 0; flt_thermal = 0;
            st("R9", S_DG);
            qualify("R3");
            eco_to_play();
            st("R9", S_PLAY);
        end

        // R8: release from Dump goes to qualification, not back to Play
        ov_above = 1; tick(); st("R8", S_DUMP);
        ov_above = 0; tick(); st("R8", S_DG);
        qualify("R3");

        // R10: each drop-out cause, the first together with overvoltage (R12)
        for (int c = 0; c < 4; c++) begin
            en_off = (c == 0); en_valid = (c != 0); ov_above = (c == 0);
            supply_reset = (c == 1); pll_lock = (c != 2); i2s_clk_ok = (c != 3);
            tick();
            st("R10", S_SB);
            tick();
            st("R10", S_SB);
            en_off = 0; en_valid = 1; ov_above = 0; supply_reset = 0;
            pll_lock = 1; i2s_clk_ok = 1;
            tick();
            st("R2", S_DG);
            qualify("R3");
        end

        // R10 from Play
        eco_to_play();
        pll_lock = 0; tick(); pll_lock = 1;
        st("R10", S_SB);
        chk("R1", "stable_fault", int'(stable_fault), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule